// File: doc/BRIEF.md
# Leaf Power Level Request Agent

This block sits at a leaf of a tree of power controllers, beside one compute resource. It holds the resource's present power level, one of five ordered steps from lowest to highest. Local logic offers a desired level with a one-cycle strobe. When that level is legal and differs from the present one, the agent raises a request to its parent controller. It then stays pending until the parent answers with a grant or a deny.

Every answer from the parent is acknowledged with a one-cycle pulse. A grant moves the present level to the requested one on the acknowledge cycle. A deny leaves the level as it was. When the step-down retry input is set, a refused upward request is followed at once by a new request one step lower. This repeats until the next step down would equal the present level. The agent does not drive any clock or voltage itself, and it does not choose the desired level.

Top module: `pwr_leaf_agent`

## Requirements
- R1: Levels are coded 0 = L, 1 = ML, 2 = M, 3 = MH, 4 = H. After reset the present level is 0, and it never holds a code above 4.
- R2: A desire strobe taken while idle, with a legal level different from the present level, raises `req_valid` in the next cycle with `req_level` equal to the desired level. A desired level equal to the present level raises no request.
- R3: A desire strobe with code 5, 6 or 7 is ignored, and so is any strobe while the agent is not idle. `req_level` stays constant for as long as a request is pending.
- R4: `ack` is a one-cycle pulse in the cycle after the parent's grant or deny is sampled during a pending request.
- R5: After a grant, `cur_level` takes the requested level at the clock edge that ends the `ack` cycle. After a deny it is unchanged.
- R6: If grant and deny are both seen in the same cycle, the answer is treated as a grant.
- R7: With `retry_en` low, a deny returns the agent to idle with no further request.
- R8: With `retry_en` high, a denied upward request is followed, in the cycle after `ack`, by a request for the level one below the refused one.
- R9: Retrying ends in idle when one below the refused level equals the present level. A denied downward request is never retried.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| want_valid | input | 1 | One-cycle strobe that offers a desired level |
| want_level | input | LVL_W | Desired level code |
| retry_en | input | 1 | Enables step-down retry after an upward deny |
| req_valid | output | 1 | A request is pending at the parent |
| req_level | output | LVL_W | Level requested from the parent |
| rsp_grant | input | 1 | Parent grants the pending request |
| rsp_deny | input | 1 | Parent refuses the pending request |
| ack | output | 1 | One-cycle acknowledge of the parent's answer |
| cur_level | output | LVL_W | Present power level of the resource |

## Verification
The bench builds the agent with its default of five levels, which gives a three-bit code with three illegal values. This small space lets the bench sweep every pair of present and desired code, all eight codes, under a grant. It then sweeps every legal pair under a deny, with retry both off and on. With retry on and the parent refusing every request, the full step-down chain from each start point is reached, and its length is known arithmetically as the gap between the two levels. Single scenarios cover a grant partway down a chain, simultaneous grant and deny, and a strobe arriving while a request is pending.

// File: rtl/pwr_leaf_pkg.sv
package pwr_leaf_pkg;

  typedef enum logic [1:0] {
    AG_IDLE = 2'd0,
    AG_PEND = 2'd1,
    AG_ACK  = 2'd2
  } agent_state_e;

endpackage

// File: rtl/pwr_want_filter.sv
module pwr_want_filter #(
  parameter int unsigned NUM_LVLS = 5,
  parameter int unsigned LVL_W    = $clog2(NUM_LVLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             want_valid,
  input  logic [LVL_W-1:0] want_level,
  input  logic [LVL_W-1:0] cur_level,
  input  logic             idle,
  output logic             start,
  output logic [LVL_W-1:0] start_level
);

  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NUM_LVLS - 1);

  function automatic logic lvl_legal(input logic [LVL_W-1:0] l);
    return l <= TOP_LVL;
  endfunction

  function automatic logic needs_change(input logic [LVL_W-1:0] want,
                                        input logic [LVL_W-1:0] cur);
    return lvl_legal(want) && (want != cur);
  endfunction

  assign start       = want_valid && idle && needs_change(want_level, cur_level);
  assign start_level = want_level;

  // R3: a start is only ever produced for a legal code
  a_r3_start_legal: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (start_level <= TOP_LVL));

endmodule

// File: rtl/pwr_handshake.sv
module pwr_handshake #(
  parameter int unsigned NUM_LVLS = 5,
  parameter int unsigned LVL_W    = $clog2(NUM_LVLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LVL_W-1:0] start_level,
  input  logic [LVL_W-1:0] cur_level,
  input  logic             retry_en,
  input  logic             rsp_grant,
  input  logic             rsp_deny,
  output logic             req_valid,
  output logic [LVL_W-1:0] req_level,
  output logic             ack,
  output logic             apply,
  output logic [LVL_W-1:0] apply_level,
  output logic             idle
);

  import pwr_leaf_pkg::*;

  agent_state_e     state_q;
  logic [LVL_W-1:0] tgt_q;
  logic             granted_q;

  function automatic logic may_retry(input logic [LVL_W-1:0] refused,
                                     input logic [LVL_W-1:0] cur);
    return (refused > cur) && ((refused - 1'b1) != cur);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= AG_IDLE;
      tgt_q     <= '0;
      granted_q <= 1'b0;
    end else begin
      unique case (state_q)
        AG_IDLE: if (start) begin
          tgt_q   <= start_level;
          state_q <= AG_PEND;
        end
        AG_PEND: if (rsp_grant) begin
          granted_q <= 1'b1;
          state_q   <= AG_ACK;
        end else if (rsp_deny) begin
          granted_q <= 1'b0;
          state_q   <= AG_ACK;
        end
        AG_ACK: begin
          if (!granted_q && retry_en && may_retry(tgt_q, cur_level)) begin
            tgt_q   <= tgt_q - 1'b1;
            state_q <= AG_PEND;
          end else begin
            state_q <= AG_IDLE;
          end
        end
        default: state_q <= AG_IDLE;
      endcase
    end
  end

  assign req_valid   = (state_q == AG_PEND);
  assign req_level   = tgt_q;
  assign ack         = (state_q == AG_ACK);
  assign apply       = ack && granted_q;
  assign apply_level = tgt_q;
  assign idle        = (state_q == AG_IDLE);

  // R4: acknowledge lasts exactly one cycle
  a_r4_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R4: acknowledge only follows an answer seen while pending
  a_r4_ack_follows_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(req_valid && (rsp_grant || rsp_deny)));

  // R3: requested level constant while pending
  a_r3_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(req_valid)) |-> $stable(req_level));

  // R8: a request that follows an acknowledge is one step lower
  a_r8_retry_one_below: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(ack)) |-> (req_level == $past(req_level) - 1'b1));

endmodule

// File: rtl/pwr_level_reg.sv
module pwr_level_reg #(
  parameter int unsigned NUM_LVLS  = 5,
  parameter int unsigned LVL_W     = $clog2(NUM_LVLS),
  parameter int unsigned RESET_LVL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             apply,
  input  logic [LVL_W-1:0] apply_level,
  output logic [LVL_W-1:0] cur_level
);

  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NUM_LVLS - 1);
  localparam logic [LVL_W-1:0] RST_LVL = LVL_W'(RESET_LVL);

  logic [LVL_W-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     lvl_q <= RST_LVL;
    else if (apply) lvl_q <= apply_level;
  end

  assign cur_level = lvl_q;

  // R5: level moves only on a granted acknowledge
  a_r5_change_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_level) |-> $past(apply));

  // R1: level code always legal
  a_r1_level_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cur_level <= TOP_LVL);

endmodule

// File: rtl/pwr_leaf_agent.sv
module pwr_leaf_agent #(
  parameter int unsigned NUM_LVLS  = 5,
  parameter int unsigned LVL_W     = $clog2(NUM_LVLS),
  parameter int unsigned RESET_LVL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             want_valid,
  input  logic [LVL_W-1:0] want_level,
  input  logic             retry_en,
  output logic             req_valid,
  output logic [LVL_W-1:0] req_level,
  input  logic             rsp_grant,
  input  logic             rsp_deny,
  output logic             ack,
  output logic [LVL_W-1:0] cur_level
);

  logic             start;
  logic [LVL_W-1:0] start_level;
  logic             apply;
  logic [LVL_W-1:0] apply_level;
  logic             idle;

  pwr_want_filter #(.NUM_LVLS(NUM_LVLS), .LVL_W(LVL_W)) u_filter (
    .clk         (clk),
    .rst_n       (rst_n),
    .want_valid  (want_valid),
    .want_level  (want_level),
    .cur_level   (cur_level),
    .idle        (idle),
    .start       (start),
    .start_level (start_level)
  );

  pwr_handshake #(.NUM_LVLS(NUM_LVLS), .LVL_W(LVL_W)) u_hs (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_level (start_level),
    .cur_level   (cur_level),
    .retry_en    (retry_en),
    .rsp_grant   (rsp_grant),
    .rsp_deny    (rsp_deny),
    .req_valid   (req_valid),
    .req_level   (req_level),
    .ack         (ack),
    .apply       (apply),
    .apply_level (apply_level),
    .idle        (idle)
  );

  pwr_level_reg #(.NUM_LVLS(NUM_LVLS), .LVL_W(LVL_W), .RESET_LVL(RESET_LVL)) u_lvl (
    .clk         (clk),
    .rst_n       (rst_n),
    .apply       (apply),
    .apply_level (apply_level),
    .cur_level   (cur_level)
  );

  // R2: never ask the parent for the level already held
  a_r2_req_differs: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_level != cur_level));

  // R9: a retried request always lies above the present level
  a_r9_retry_above: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && $past(ack)) |-> (req_level > cur_level));

endmodule

// File: tb/pwr_leaf_agent_tb.sv
module pwr_leaf_agent_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       want_valid = 1'b0;
  logic [2:0] want_level = '0;
  logic       retry_en = 1'b0;
  logic       req_valid;
  logic [2:0] req_level;
  logic       rsp_grant = 1'b0;
  logic       rsp_deny = 1'b0;
  logic       ack;
  logic [2:0] cur_level;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pwr_leaf_agent u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .want_valid (want_valid),
    .want_level (want_level),
    .retry_en   (retry_en),
    .req_valid  (req_valid),
    .req_level  (req_level),
    .rsp_grant  (rsp_grant),
    .rsp_deny   (rsp_deny),
    .ack        (ack),
    .cur_level  (cur_level)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic want(input int l);
    @(negedge clk);
    want_valid = 1'b1;
    want_level = 3'(l);
    @(negedge clk);
    want_valid = 1'b0;
  endtask

  // called at a negedge while pending; returns at the negedge after the ack cycle
  task automatic answer(input bit g, input bit d);
    rsp_grant = g;
    rsp_deny  = d;
    @(negedge clk);
    rsp_grant = 1'b0;
    rsp_deny  = 1'b0;
    chk("R4 ack high", int'(ack), 1);
    @(negedge clk);
    chk("R4 ack low", int'(ack), 0);
  endtask

  task automatic goto_lvl(input int c);
    if (int'(cur_level) != c) begin
      want(c);
      answer(1'b1, 1'b0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset level", int'(cur_level), 0);
    chk("R1 reset req", int'(req_valid), 0);
    chk("R4 reset ack", int'(ack), 0);

    // grant sweep over every present/desired code pair (R2, R3, R5)
    for (int c = 0; c < 5; c++) begin
      for (int t = 0; t < 8; t++) begin
        goto_lvl(c);
        want(t);
        if (t < 5 && t != c) begin
          chk("R2 req raised", int'(req_valid), 1);
          chk("R2 req level", int'(req_level), t);
          answer(1'b1, 1'b0);
          chk("R5 grant level", int'(cur_level), t);
          chk("R1 level legal", int'(cur_level <= 3'd4), 1);
        end else begin
          chk(t < 5 ? "R2 same no req" : "R3 illegal no req", int'(req_valid), 0);
          @(negedge clk);
          chk("R3 level unchanged", int'(cur_level), c);
        end
      end
    end

    // deny sweep, retry off (R5, R7)
    retry_en = 1'b0;
    for (int c = 0; c < 5; c++) begin
      for (int t = 0; t < 5; t++) begin
        if (t == c) continue;
        goto_lvl(c);
        want(t);
        answer(1'b0, 1'b1);
        chk("R7 idle after deny", int'(req_valid), 0);
        chk("R5 deny keeps level", int'(cur_level), c);
      end
    end

    // deny sweep, retry on, parent refuses everything (R8, R9)
    retry_en = 1'b1;
    for (int c = 0; c < 5; c++) begin
      for (int t = 0; t < 5; t++) begin
        if (t == c) continue;
        goto_lvl(c);
        want(t);
        if (t > c) begin
          for (int e = t; e > c; e--) begin
            chk("R8 chain req", int'(req_valid), 1);
            chk("R8 chain level", int'(req_level), e);
            answer(1'b0, 1'b1);
          end
        end else begin
          chk("R9 down req level", int'(req_level), t);
          answer(1'b0, 1'b1);
        end
        chk("R9 chain ends idle", int'(req_valid), 0);
        chk("R9 level kept", int'(cur_level), c);
      end
    end

    // retry then grant partway (R8, R5)
    goto_lvl(0);
    want(4);
    answer(1'b0, 1'b1);
    chk("R8 step to 3", int'(req_level), 3);
    answer(1'b0, 1'b1);
    chk("R8 step to 2", int'(req_level), 2);
    answer(1'b1, 1'b0);
    chk("R5 partway grant", int'(cur_level), 2);
    chk("R5 idle after grant", int'(req_valid), 0);
    retry_en = 1'b0;

    // grant and deny together (R6)
    goto_lvl(1);
    want(3);
    answer(1'b1, 1'b1);
    chk("R6 both means grant", int'(cur_level), 3);

    // strobe while pending is ignored (R3)
    goto_lvl(0);
    want(3);
    @(negedge clk);
    want_valid = 1'b1;
    want_level = 3'd1;
    @(negedge clk);
    want_valid = 1'b0;
    chk("R3 pending req kept", int'(req_valid), 1);
    chk("R3 pending level kept", int'(req_level), 3);
    answer(1'b1, 1'b0);
    chk("R3 pending strobe dropped", int'(cur_level), 3);
    chk("R3 no follow-up req", int'(req_valid), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule